// File: doc/BRIEF.md
# Multiprocessor-Mode Asynchronous Serial Receiver

This block receives asynchronous serial characters on a line that many stations share. Each character carries one extra bit after its data bits, the multiprocessor bit. A value of 1 marks the character as a station address. A value of 0 marks it as payload. Parity is neither generated nor checked in this format. The line is oversampled by an external tick at sixteen times the bit rate. Every bit is decided by a three-sample majority vote near the middle of the bit.

Software can arm a wake-up filter. While the filter is armed, payload characters are dropped silently: the buffer is not loaded and no flag moves, including the error flags. The first address character that arrives is delivered with its multiprocessor flag set, and the hardware disarms the filter. Later payload characters are then delivered as normal. Software compares the delivered address with its own station number. On a mismatch it arms the filter again and so skips the rest of that transfer.

Top module: `mpr_uart_rx`

## Requirements
- R1: A frame is one low start bit, 8 data bits least-significant bit first, the multiprocessor bit, and one high stop bit. When the filter is not armed, the 8 data bits of each frame appear on `rd_data` and `rx_full` goes to 1.
- R2: A low level on the line is accepted as a start bit only if the majority vote at the middle of the start bit is low. A shorter low pulse delivers nothing.
- R3: While `armed` is 1, a frame whose multiprocessor bit is 0 does not change `rd_data` or `rd_mpb` and does not set `rx_full`.
- R4: While `armed` is 1, a frame whose multiprocessor bit is 0 does not set `rd_ferr` or `rd_oerr`, even when its stop bit is low or the buffer is full.
- R5: A frame whose multiprocessor bit is 1 is always delivered, with `rd_mpb` = 1. It clears `armed` in hardware.
- R6: A delivered frame whose stop bit is sampled low sets `rd_ferr` to 1 together with `rx_full`.
- R7: A frame that completes while `rx_full` is 1 and that is not filtered sets `rd_oerr` to 1. The buffered `rd_data` is kept.
- R8: A one-cycle `rd_en` pulse clears `rx_full`, `rd_ferr` and `rd_oerr` on the next cycle. `rd_data` keeps its value.
- R9: A cycle with `arm_wr` = 1 loads `arm_val` into `armed`. A hardware clear by an address frame in the same cycle takes precedence.
- R10: After reset, `rx_full`, `rd_ferr`, `rd_oerr`, `rd_mpb` and `armed` are 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| arm_wr | input | 1 | Write strobe for the wake-up filter control |
| arm_val | input | 1 | Value written to the filter control |
| rd_en | input | 1 | Buffer read strobe, clears the status flags |
| rd_data | output | 8 | Buffered character data |
| rd_mpb | output | 1 | Multiprocessor bit of the buffered character |
| rd_ferr | output | 1 | Framing error flag |
| rd_oerr | output | 1 | Overrun error flag |
| rx_full | output | 1 | Buffer holds an unread character |
| armed | output | 1 | Wake-up filter is armed |

## Verification
A filter that stays armed after an address frame shows at the ports one frame later: the payload character that should follow the address never sets `rx_full`. A filter that disarms too early shows at once as a payload byte landing in `rd_data` while `armed` was still 1. A bit counter or shift register off by one slot shows within a single frame as a rotated byte or a wrong `rd_mpb`. Error flags that leak from skipped frames show on the frame itself, which is why skipped frames with a low stop bit or with the buffer full are sent on purpose.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2
    } rx_state_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/mpr_line_sync.sv
module mpr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mpr_bit_sampler.sv
module mpr_bit_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    output logic vote
);
    import mpr_pkg::*;

    logic [1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (tick) hist_d = {hist_q[0], line};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= 2'b11;
        else        hist_q <= hist_d;
    end

    assign vote = vote3(hist_q[1], hist_q[0], line);
endmodule

// File: rtl/mpr_frame_rx.sv
module mpr_frame_rx #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              vote,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              mpb,
    output logic              stop_ok
);
    import mpr_pkg::*;

    localparam int CNT_W = $clog2(OSR);
    localparam int SLOTS = DATA_W + 2;
    localparam int IDX_W = $clog2(SLOTS + 1);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(SLOTS - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  tcnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W:0]   shreg;
        logic              done;
        logic              stop_ok;
    } frm_t;

    frm_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (tick) begin
            unique case (st_q.state)
                RX_IDLE: begin
                    if (!line) begin
                        st_d.state = RX_START;
                        st_d.tcnt  = '0;
                    end
                end
                RX_START: begin
                    if (st_q.tcnt == MID) begin
                        st_d.tcnt = '0;
                        st_d.idx  = '0;
                        st_d.state = vote ? RX_IDLE : RX_BITS;
                    end else begin
                        st_d.tcnt = st_q.tcnt + 1'b1;
                    end
                end
                RX_BITS: begin
                    if (st_q.tcnt == LAST) begin
                        st_d.tcnt = '0;
                        if (st_q.idx == STOP_IDX) begin
                            st_d.done    = 1'b1;
                            st_d.stop_ok = vote;
                            st_d.state   = RX_IDLE;
                        end else begin
                            st_d.shreg = {vote, st_q.shreg[DATA_W:1]};
                            st_d.idx   = st_q.idx + 1'b1;
                        end
                    end else begin
                        st_d.tcnt = st_q.tcnt + 1'b1;
                    end
                end
                default: st_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.state   <= RX_IDLE;
            st_q.stop_ok <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign done    = st_q.done;
    assign data    = st_q.shreg[DATA_W-1:0];
    assign mpb     = st_q.shreg[DATA_W];
    assign stop_ok = st_q.stop_ok;
endmodule

// File: rtl/mpr_rx_buffer.sv
module mpr_rx_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic              mpb,
    input  logic              stop_ok,
    input  logic              arm_wr,
    input  logic              arm_val,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_mpb,
    output logic              rd_ferr,
    output logic              rd_oerr,
    output logic              rx_full,
    output logic              armed
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mpb;
        logic              ferr;
        logic              oerr;
        logic              full;
        logic              armed;
    } buf_t;

    buf_t bf_d, bf_q;
    logic full_now;
    logic skip;

    always_comb begin
        bf_d     = bf_q;
        full_now = bf_q.full;
        skip     = bf_q.armed && !mpb;
        if (rd_en) begin
            bf_d.full = 1'b0;
            bf_d.ferr = 1'b0;
            bf_d.oerr = 1'b0;
            full_now  = 1'b0;
        end
        if (arm_wr) bf_d.armed = arm_val;
        if (done && !skip) begin
            if (full_now) begin
                bf_d.oerr = 1'b1;
            end else begin
                bf_d.data = data;
                bf_d.mpb  = mpb;
                bf_d.ferr = !stop_ok;
                bf_d.full = 1'b1;
            end
            if (mpb) bf_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bf_q <= '0;
        else        bf_q <= bf_d;
    end

    assign rd_data = bf_q.data;
    assign rd_mpb  = bf_q.mpb;
    assign rd_ferr = bf_q.ferr;
    assign rd_oerr = bf_q.oerr;
    assign rx_full = bf_q.full;
    assign armed   = bf_q.armed;
endmodule

// File: rtl/mpr_uart_rx.sv
module mpr_uart_rx #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic              arm_wr,
    input  logic              arm_val,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_mpb,
    output logic              rd_ferr,
    output logic              rd_oerr,
    output logic              rx_full,
    output logic              armed
);
    logic              line_s;
    logic              vote;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_mpb;
    logic              frm_stop_ok;

    mpr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
    );

    mpr_bit_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s), .vote(vote)
    );

    mpr_frame_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_frm (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s), .vote(vote),
        .done(frm_done), .data(frm_data), .mpb(frm_mpb), .stop_ok(frm_stop_ok)
    );

    mpr_rx_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .done(frm_done), .data(frm_data),
        .mpb(frm_mpb), .stop_ok(frm_stop_ok), .arm_wr(arm_wr), .arm_val(arm_val),
        .rd_en(rd_en), .rd_data(rd_data), .rd_mpb(rd_mpb), .rd_ferr(rd_ferr),
        .rd_oerr(rd_oerr), .rx_full(rx_full), .armed(armed)
    );
endmodule

// File: rtl/mpr_uart_rx_chk.sv
module mpr_uart_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm_wr,
    input logic              arm_val,
    input logic              rd_en,
    input logic              frm_done,
    input logic              frm_mpb,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_ferr,
    input logic              rd_oerr,
    input logic              rx_full,
    input logic              armed
);
    p_skip_no_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && frm_done && !frm_mpb && !rd_en && !rx_full) |=> !rx_full);

    p_skip_no_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && frm_done && !frm_mpb && !rd_en) |=> ($stable(rd_ferr) && $stable(rd_oerr)));

    p_id_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_mpb) |=> !armed);

    p_overrun_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && rx_full && !rd_en && !(armed && !frm_mpb)) |=> (rd_oerr && $stable(rd_data)));

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !frm_done) |=> (!rx_full && !rd_ferr && !rd_oerr));

    p_arm_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_wr && arm_val && !(frm_done && frm_mpb)) |=> armed);
endmodule

bind mpr_uart_rx mpr_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .arm_val(arm_val), .rd_en(rd_en),
    .frm_done(frm_done), .frm_mpb(frm_mpb), .rd_data(rd_data), .rd_ferr(rd_ferr),
    .rd_oerr(rd_oerr), .rx_full(rx_full), .armed(armed)
);

// File: tb/sim_mpr_uart_rx.sv
module sim_mpr_uart_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic       arm_wr = 1'b0;
    logic       arm_val = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_mpb, rd_ferr, rd_oerr, rx_full, armed;

    int checks = 0;
    int errors = 0;
    logic [1:0] tdiv = '0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) begin
        tdiv    <= tdiv + 1'b1;
        os_tick <= (tdiv == 2'd3);
    end

    mpr_uart_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
        .arm_wr(arm_wr), .arm_val(arm_val), .rd_en(rd_en), .rd_data(rd_data),
        .rd_mpb(rd_mpb), .rd_ferr(rd_ferr), .rd_oerr(rd_oerr),
        .rx_full(rx_full), .armed(armed)
    );

    typedef struct packed {
        logic       arm;
        logic       rd;
        logic [7:0] chr;
        logic       mpb;
        logic       stok;
        logic       e_full;
        logic [7:0] e_data;
        logic       e_mpb;
        logic       e_ferr;
        logic       e_oerr;
        logic       e_armed;
    } vec_t;

    // arm, rd, char, mpb, stop_ok | full, data, mpb, ferr, oerr, armed
    localparam vec_t VEC [10] = '{
        '{1'b1, 1'b0, 8'h33, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 skipped payload
        '{1'b0, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 skipped bad stop
        '{1'b0, 1'b0, 8'h01, 1'b1, 1'b1, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 address 01h
        '{1'b0, 1'b1, 8'hAA, 1'b0, 1'b1, 1'b1, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 payload AAh
        '{1'b1, 1'b1, 8'h02, 1'b1, 1'b1, 1'b1, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 address 02h
        '{1'b1, 1'b1, 8'h55, 1'b0, 1'b1, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 re-armed skip
        '{1'b0, 1'b0, 8'h66, 1'b0, 1'b0, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 skipped bad stop
        '{1'b0, 1'b0, 8'h01, 1'b1, 1'b1, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 address again
        '{1'b0, 1'b0, 8'h77, 1'b0, 1'b1, 1'b1, 8'h01, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 overrun
        '{1'b0, 1'b1, 8'h88, 1'b0, 1'b0, 1'b1, 8'h88, 1'b0, 1'b1, 1'b0, 1'b0}  // R6 framing
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!os_tick);
        end
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic do_arm();
        @(negedge clk) begin arm_wr = 1'b1; arm_val = 1'b1; end
        @(negedge clk) arm_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] chr, input logic mpb, input logic stok);
        logic [9:0] bits;
        bits = {mpb, chr};
        bits = {bits[8:0], 1'b0};
        @(negedge clk) rx_line = 1'b0;
        wait_ticks(16);
        for (int b = 0; b < 9; b++) begin
            @(negedge clk) rx_line = (b < 8) ? chr[b] : mpb;
            wait_ticks(16);
        end
        @(negedge clk) rx_line = stok;
        wait_ticks(stok ? 16 : 10);
        @(negedge clk) rx_line = 1'b1;
        wait_ticks(stok ? 16 : 22);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 rx_full", {7'd0, rx_full}, 8'd0);
        chk("R10 rd_data", rd_data, 8'd0);
        chk("R10 rd_mpb", {7'd0, rd_mpb}, 8'd0);
        chk("R10 ferr/oerr", {6'd0, rd_ferr, rd_oerr}, 8'd0);
        chk("R10 armed", {7'd0, armed}, 8'd0);

        for (int v = 0; v < 10; v++) begin
            if (VEC[v].rd)  pulse_rd();
            if (VEC[v].arm) do_arm();
            send(VEC[v].chr, VEC[v].mpb, VEC[v].stok);
            chk($sformatf("R3 rx_full vec%0d", v), {7'd0, rx_full}, {7'd0, VEC[v].e_full});
            chk($sformatf("R1 rd_data vec%0d", v), rd_data, VEC[v].e_data);
            chk($sformatf("R5 rd_mpb vec%0d", v), {7'd0, rd_mpb}, {7'd0, VEC[v].e_mpb});
            chk($sformatf("R6 rd_ferr vec%0d", v), {7'd0, rd_ferr}, {7'd0, VEC[v].e_ferr});
            chk($sformatf("R7 rd_oerr vec%0d", v), {7'd0, rd_oerr}, {7'd0, VEC[v].e_oerr});
            chk($sformatf("R9 armed vec%0d", v), {7'd0, armed}, {7'd0, VEC[v].e_armed});
        end

        // R8 read clears flags, data kept
        pulse_rd();
        chk("R8 rx_full", {7'd0, rx_full}, 8'd0);
        chk("R8 rd_ferr", {7'd0, rd_ferr}, 8'd0);
        chk("R8 rd_oerr", {7'd0, rd_oerr}, 8'd0);
        chk("R8 rd_data kept", rd_data, 8'h88);

        // R2 short low pulse is not a start bit
        @(negedge clk) rx_line = 1'b0;
        wait_ticks(4);
        @(negedge clk) rx_line = 1'b1;
        wait_ticks(40);
        @(negedge clk);
        chk("R2 glitch rx_full", {7'd0, rx_full}, 8'd0);
        chk("R2 glitch rd_data", rd_data, 8'h88);

        // R9 arm write sets armed
        do_arm();
        chk("R9 armed set", {7'd0, armed}, 8'd1);

        // R4 skipped payload with buffer full must not raise overrun
        send(8'h10, 1'b1, 1'b1);
        chk("R5 addr 10h", rd_data, 8'h10);
        do_arm();
        send(8'h20, 1'b0, 1'b1);
        chk("R4 no overrun on skip", {7'd0, rd_oerr}, 8'd0);
        chk("R4 data kept on skip", rd_data, 8'h10);
        chk("R4 full still set", {7'd0, rx_full}, 8'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule